// File: doc/BRIEF.md
# Multi-Thread Fetch Eligibility Arbiter

This block watches a fixed set of thread slots and starts at most one instruction fetch per clock. Each slot reports its execution state, whether its line buffer can take another line, and a stop request. A slot that can fetch joins a ready queue once. Each cycle the queue head is removed, and it is granted if it can still fetch. A granted slot holds a pending mark until its response comes back, so it cannot issue a second fetch while the first is unresolved.

A slot that is redirected while a fetch is in flight can ask for that fetch to be discarded. Its drop mark is then set. When the response for a marked slot returns, the data is refused and the mark clears. The pending mark clears on every response, whether the data was accepted or not. Address translation and the memory interface are outside this block. They see only the grant and send back the response strobe and slot index.

Top module: `fa_arb`

## Requirements
- R1: While reset is asserted and right after it is released, `grant_valid_o` is low, every bit of `pending_o` is clear, and the ready queue is empty.
- R2: A slot can fetch only when all four of these hold: its 2-bit state field is 01 (running) or 10 (waiting on a counter), its `buf_free_i` bit is high, its `stop_fetch_i` bit is low, and its pending bit is clear. States 00 (idle) and 11 (done) never fetch.
- R3: A slot that can fetch and is not in the queue is appended at the clock edge, and it is never held twice. The earliest grant comes in the cycle after its first eligible cycle.
- R4: Grants follow queue order, oldest first. Slots that enter in the same cycle are ordered by ascending index.
- R5: Whenever the queue holds an entry, its head is removed in that cycle. The grant is raised only if the head can still fetch under R2. Otherwise the grant is suppressed, and the slot is evaluated again from the next cycle.
- R6: A grant sets the granted slot's pending bit at the next edge, and that slot is not granted again while the bit is set.
- R7: A bit of `drop_req_i` sets the drop mark only for a slot whose pending bit is set. On any other slot it has no effect.
- R8: `rsp_keep_o` is high in the cycle of a response only if the named slot is pending and not drop-marked. A response clears the slot's drop mark.
- R9: A response clears the named slot's pending bit at the next edge, whether the data was kept or discarded.
- R10: When the queue is empty, `grant_valid_o` stays low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released in step with clk |
| thr_state_i | input | 2*NTHR | Execution state per slot, slot i at bits [2i+1:2i] |
| buf_free_i | input | NTHR | Slot's line buffer can accept another line |
| stop_fetch_i | input | NTHR | Slot asks that no new fetch be issued |
| drop_req_i | input | NTHR | Discard the slot's outstanding fetch on return |
| rsp_valid_i | input | 1 | A fetch response returns this cycle |
| rsp_thr_i | input | TW | Slot index of the returning response |
| grant_valid_o | output | 1 | A fetch is started this cycle |
| grant_thr_o | output | TW | Slot index of the started fetch |
| rsp_keep_o | output | 1 | The returning data is accepted |
| pending_o | output | NTHR | Per-slot fetch-outstanding marks |

## Verification
The bench first targets ordering. One slot enters a cycle ahead of two others that arrive together, so an arbiter that picked by index would grant them in the wrong order. Next, a queued slot is stopped just as it reaches the head. A design that granted it anyway would issue a fetch for a stopped slot. A design that left the slot in the queue without clearing its membership would never grant it again. The drop path is driven both on a pending slot, where the data must be refused, and on an idle slot, where a design that latched the request would wrongly refuse a later good response. A long random run then mixes stray responses, state changes and mid-run resets against the behavioural model.

// File: rtl/fa_pkg.sv
package fa_pkg;
  typedef enum logic [1:0] {
    TS_IDLE = 2'b00,
    TS_RUN  = 2'b01,
    TS_WAIT = 2'b10,
    TS_DONE = 2'b11
  } thr_state_e;

  function automatic logic state_can_fetch(input logic [1:0] st);
    return (st == TS_RUN) || (st == TS_WAIT);
  endfunction
endpackage

// File: rtl/fa_elig.sv
module fa_elig #(
  parameter int NTHR = 4
) (
  input  logic [2*NTHR-1:0] thr_state_i,
  input  logic [NTHR-1:0]   buf_free_i,
  input  logic [NTHR-1:0]   stop_fetch_i,
  input  logic [NTHR-1:0]   pending_i,
  output logic [NTHR-1:0]   elig_o
);
  import fa_pkg::*;

  for (genvar g = 0; g < NTHR; g++) begin : g_slot
    logic [1:0] st;
    assign st = thr_state_i[2*g +: 2];
    assign elig_o[g] = state_can_fetch(st) & buf_free_i[g] &
                       ~stop_fetch_i[g] & ~pending_i[g];
  end
endmodule

// File: rtl/fa_rdyq.sv
module fa_rdyq #(
  parameter int NTHR = 4,
  localparam int TW = (NTHR > 1) ? $clog2(NTHR) : 1,
  localparam int CW = $clog2(NTHR + 1)
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [NTHR-1:0] elig_i,
  output logic            head_vld_o,
  output logic [TW-1:0]   head_o
);
  logic [TW-1:0]   slot_q [NTHR];
  logic [TW-1:0]   slot_n [NTHR];
  logic [CW-1:0]   cnt_q, cnt_n;
  logic [NTHR-1:0] inq_q, inq_n;
  logic [NTHR-1:0] push;
  logic [NTHR-1:0] pop_hot;
  logic            pop;
  logic            upd_en;

  assign head_vld_o = (cnt_q != '0);
  assign head_o     = slot_q[0];
  assign pop        = head_vld_o;
  assign push       = elig_i & ~inq_q;
  assign upd_en     = pop | (|push);

  always_comb begin
    pop_hot = '0;
    if (pop) pop_hot[head_o] = 1'b1;
  end

  always_comb begin
    logic [CW-1:0] fill;
    for (int s = 0; s < NTHR; s++) slot_n[s] = slot_q[s];
    fill = cnt_q;
    if (pop) begin
      for (int s = 0; s < NTHR - 1; s++) slot_n[s] = slot_q[s+1];
      fill = fill - CW'(1);
    end
    for (int i = 0; i < NTHR; i++) begin
      if (push[i] && (fill < CW'(NTHR))) begin
        slot_n[TW'(fill)] = TW'(i);
        fill = fill + CW'(1);
      end
    end
    cnt_n = fill;
    inq_n = (inq_q & ~pop_hot) | push;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      inq_q <= '0;
      for (int s = 0; s < NTHR; s++) slot_q[s] <= '0;
    end else if (upd_en) begin
      cnt_q <= cnt_n;
      inq_q <= inq_n;
      for (int s = 0; s < NTHR; s++) slot_q[s] <= slot_n[s];
    end
  end
endmodule

// File: rtl/fa_track.sv
module fa_track #(
  parameter int NTHR = 4,
  localparam int TW = (NTHR > 1) ? $clog2(NTHR) : 1
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            grant_vld_i,
  input  logic [TW-1:0]   grant_thr_i,
  input  logic            rsp_vld_i,
  input  logic [TW-1:0]   rsp_thr_i,
  input  logic [NTHR-1:0] drop_req_i,
  output logic [NTHR-1:0] pending_o,
  output logic [NTHR-1:0] drop_o
);
  logic [NTHR-1:0] pend_q, pend_n;
  logic [NTHR-1:0] drop_q, drop_n;
  logic [NTHR-1:0] grant_hit, rsp_hit;
  logic            upd_en;

  always_comb begin
    grant_hit = '0;
    rsp_hit   = '0;
    if (grant_vld_i) grant_hit[grant_thr_i] = 1'b1;
    if (rsp_vld_i)   rsp_hit[rsp_thr_i]     = 1'b1;
  end

  assign upd_en = grant_vld_i | rsp_vld_i | (|drop_req_i);

  for (genvar g = 0; g < NTHR; g++) begin : g_flag
    assign pend_n[g] = grant_hit[g] | (pend_q[g] & ~rsp_hit[g]);
    assign drop_n[g] = rsp_hit[g] ? 1'b0
                                  : (drop_q[g] | (drop_req_i[g] & pend_q[g]));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_q <= '0;
      drop_q <= '0;
    end else if (upd_en) begin
      pend_q <= pend_n;
      drop_q <= drop_n;
    end
  end

  assign pending_o = pend_q;
  assign drop_o    = drop_q;
endmodule

// File: rtl/fa_arb.sv
module fa_arb #(
  parameter int NTHR = 4,
  localparam int TW = (NTHR > 1) ? $clog2(NTHR) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [2*NTHR-1:0] thr_state_i,
  input  logic [NTHR-1:0]   buf_free_i,
  input  logic [NTHR-1:0]   stop_fetch_i,
  input  logic [NTHR-1:0]   drop_req_i,
  input  logic              rsp_valid_i,
  input  logic [TW-1:0]     rsp_thr_i,
  output logic              grant_valid_o,
  output logic [TW-1:0]     grant_thr_o,
  output logic              rsp_keep_o,
  output logic [NTHR-1:0]   pending_o
);
  logic [NTHR-1:0] elig;
  logic [NTHR-1:0] pend;
  logic [NTHR-1:0] drop;
  logic            head_vld;
  logic [TW-1:0]   head;

  fa_elig #(.NTHR(NTHR)) u_elig (
    .thr_state_i  (thr_state_i),
    .buf_free_i   (buf_free_i),
    .stop_fetch_i (stop_fetch_i),
    .pending_i    (pend),
    .elig_o       (elig)
  );

  fa_rdyq #(.NTHR(NTHR)) u_rdyq (
    .clk        (clk),
    .rst_n      (rst_n),
    .elig_i     (elig),
    .head_vld_o (head_vld),
    .head_o     (head)
  );

  assign grant_valid_o = head_vld & elig[head];
  assign grant_thr_o   = head;

  fa_track #(.NTHR(NTHR)) u_track (
    .clk         (clk),
    .rst_n       (rst_n),
    .grant_vld_i (grant_valid_o),
    .grant_thr_i (head),
    .rsp_vld_i   (rsp_valid_i),
    .rsp_thr_i   (rsp_thr_i),
    .drop_req_i  (drop_req_i),
    .pending_o   (pend),
    .drop_o      (drop)
  );

  assign rsp_keep_o = rsp_valid_i & pend[rsp_thr_i] & ~drop[rsp_thr_i];
  assign pending_o  = pend;
endmodule

// File: rtl/fa_arb_chk.sv
module fa_arb_chk #(
  parameter int NTHR = 4,
  localparam int TW = (NTHR > 1) ? $clog2(NTHR) : 1
) (
  input logic              clk,
  input logic              rst_n,
  input logic [2*NTHR-1:0] thr_state_i,
  input logic [NTHR-1:0]   buf_free_i,
  input logic [NTHR-1:0]   stop_fetch_i,
  input logic              rsp_valid_i,
  input logic [TW-1:0]     rsp_thr_i,
  input logic              grant_valid_o,
  input logic [TW-1:0]     grant_thr_o,
  input logic              rsp_keep_o,
  input logic [NTHR-1:0]   pending_o
);
  logic [1:0] gst;
  assign gst = thr_state_i[2*grant_thr_o +: 2];

  assert_grant_fetchable_R2: assert property (@(posedge clk) disable iff (!rst_n)
    grant_valid_o |-> ((gst == 2'b01) || (gst == 2'b10)) &&
                      buf_free_i[grant_thr_o] && !stop_fetch_i[grant_thr_o]);

  assert_grant_not_pending_R6: assert property (@(posedge clk) disable iff (!rst_n)
    grant_valid_o |-> !pending_o[grant_thr_o]);

  assert_grant_sets_pending_R6: assert property (@(posedge clk) disable iff (!rst_n)
    grant_valid_o |=> pending_o[$past(grant_thr_o)]);

  assert_keep_needs_pending_R8: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_keep_o |-> rsp_valid_i && pending_o[rsp_thr_i]);

  assert_rsp_clears_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid_i && !(grant_valid_o && grant_thr_o == rsp_thr_i))
      |=> !pending_o[$past(rsp_thr_i)]);

  for (genvar g = 0; g < NTHR; g++) begin : g_rise
    assert_pending_from_grant_R6: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(pending_o[g]) |-> $past(grant_valid_o) && ($past(grant_thr_o) == TW'(g)));
  end
endmodule

bind fa_arb fa_arb_chk #(.NTHR(NTHR)) u_chk (
  .clk           (clk),
  .rst_n         (rst_n),
  .thr_state_i   (thr_state_i),
  .buf_free_i    (buf_free_i),
  .stop_fetch_i  (stop_fetch_i),
  .rsp_valid_i   (rsp_valid_i),
  .rsp_thr_i     (rsp_thr_i),
  .grant_valid_o (grant_valid_o),
  .grant_thr_o   (grant_thr_o),
  .rsp_keep_o    (rsp_keep_o),
  .pending_o     (pending_o)
);

// File: tb/fa_arb_bench.sv
module fa_arb_bench;
  localparam int N  = 4;
  localparam int TW = 2;

  logic            clk = 1'b0;
  logic            rst_n;
  logic [2*N-1:0]  st;
  logic [N-1:0]    bf, sf, dr;
  logic            rv;
  logic [TW-1:0]   rt;
  logic            gv, keep;
  logic [TW-1:0]   gt;
  logic [N-1:0]    pend;

  always #4 clk = ~clk;

  fa_arb #(.NTHR(N)) u_fa_arb (
    .clk(clk), .rst_n(rst_n), .thr_state_i(st), .buf_free_i(bf),
    .stop_fetch_i(sf), .drop_req_i(dr), .rsp_valid_i(rv), .rsp_thr_i(rt),
    .grant_valid_o(gv), .grant_thr_o(gt), .rsp_keep_o(keep), .pending_o(pend)
  );

  int checks = 0;
  int fails  = 0;
  bit done   = 0;

  int m_q[$];
  bit m_inq [N];
  bit m_pend[N];
  bit m_drop[N];

  bit ob_gv, ob_keep;
  int ob_gt;

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  function automatic int pend_word();
    int w = 0;
    for (int i = 0; i < N; i++) if (m_pend[i]) w |= (1 << i);
    return w;
  endfunction

  task automatic model_clear();
    m_q.delete();
    for (int i = 0; i < N; i++) begin
      m_inq[i] = 0; m_pend[i] = 0; m_drop[i] = 0;
    end
  endtask

  // inputs are set at the falling edge before this is called
  task automatic step();
    bit elig[N];
    bit e_gv, e_keep;
    int head;
    bit old_inq[N];
    bit np[N], nd[N];
    #2;
    for (int i = 0; i < N; i++)
      elig[i] = ((st[2*i +: 2] == 2'b01) || (st[2*i +: 2] == 2'b10)) &&
                bf[i] && !sf[i] && !m_pend[i];
    e_gv = 0; head = 0;
    if (m_q.size() > 0) begin head = m_q[0]; e_gv = elig[head]; end
    e_keep = rv && m_pend[rt] && !m_drop[rt];
    ob_gv = gv; ob_gt = int'(gt); ob_keep = keep;
    chk(gv == e_gv, "R4/R5/R10 grant_valid", gv, e_gv);
    if (e_gv) chk(int'(gt) == head, "R4 grant_thr", gt, head);
    chk(keep == e_keep, "R8 rsp_keep", keep, e_keep);
    chk(int'(pend) == pend_word(), "R9 pending", pend, pend_word());
    @(posedge clk);
    for (int i = 0; i < N; i++) begin
      old_inq[i] = m_inq[i];
      np[i] = m_pend[i]; nd[i] = m_drop[i];
      if (rv && int'(rt) == i) begin np[i] = 0; nd[i] = 0; end
      else if (dr[i] && m_pend[i]) nd[i] = 1;
    end
    if (m_q.size() > 0) begin
      void'(m_q.pop_front());
      m_inq[head] = 0;
      if (e_gv) np[head] = 1;
    end
    for (int i = 0; i < N; i++) if (elig[i] && !old_inq[i]) begin
      m_q.push_back(i); m_inq[i] = 1;
    end
    for (int i = 0; i < N; i++) begin m_pend[i] = np[i]; m_drop[i] = nd[i]; end
    @(negedge clk);
  endtask

  task automatic do_reset();
    rst_n = 1'b0;
    model_clear();
    @(negedge clk);
    @(negedge clk);
    chk(gv == 1'b0, "R1 grant in reset", gv, 0);
    chk(pend == '0, "R1 pending in reset", pend, 0);
    rst_n = 1'b1;
  endtask

  task automatic set_st(input int t, input logic [1:0] v);
    st[2*t +: 2] = v;
  endtask

  initial begin
    rst_n = 1'b0; st = '0; bf = '1; sf = '0; dr = '0; rv = 1'b0; rt = '0;
    @(negedge clk);
    do_reset();
    step(); chk(ob_gv == 0, "R10 empty queue idle", ob_gv, 0);
    set_st(2, 2'b01);
    step(); chk(ob_gv == 0, "R3 no same-cycle grant", ob_gv, 0);
    step(); chk(ob_gv && ob_gt == 2, "R3 first grant slot 2", ob_gt, 2);
    chk(pend[2] == 1'b1, "R6 pending set", pend[2], 1);
    step(); chk(ob_gv == 0, "R6 no regrant while pending", ob_gv, 0);
    set_st(3, 2'b10);
    step();
    set_st(0, 2'b10); set_st(1, 2'b10);
    step(); chk(ob_gv && ob_gt == 3, "R4 oldest slot 3", ob_gt, 3);
    step(); chk(ob_gv && ob_gt == 0, "R4 tie lower index 0", ob_gt, 0);
    step(); chk(ob_gv && ob_gt == 1, "R4 tie then index 1", ob_gt, 1);
    dr[1] = 1'b1;
    step();
    dr = '0; rv = 1'b1; rt = 2'd1;
    step(); chk(ob_keep == 0, "R8 dropped data refused", ob_keep, 0);
    rv = 1'b0;
    chk(pend[1] == 1'b0, "R9 pending cleared on drop", pend[1], 0);
    step();
    sf[1] = 1'b1;
    step(); chk(ob_gv == 0, "R5 stopped head suppressed", ob_gv, 0);
    sf[1] = 1'b0;
    step(); chk(ob_gv == 0, "R5 re-enqueue cycle", ob_gv, 0);
    step(); chk(ob_gv && ob_gt == 1, "R5 regranted after re-eval", ob_gt, 1);
    rv = 1'b1; rt = 2'd2;
    step(); chk(ob_keep == 1, "R8 data kept", ob_keep, 1);
    rv = 1'b0; dr[2] = 1'b1;
    step();
    dr = '0;
    step(); chk(ob_gv && ob_gt == 2, "R3 slot 2 again", ob_gt, 2);
    rv = 1'b1; rt = 2'd2;
    step(); chk(ob_keep == 1, "R7 idle drop ignored", ob_keep, 1);
    rv = 1'b0; set_st(2, 2'b11);
    step(); step(); chk(ob_gv == 0, "R2 done state never fetches", ob_gv, 0);
    set_st(2, 2'b01); bf[2] = 1'b0;
    step(); step(); chk(ob_gv == 0, "R2 full buffer blocks", ob_gv, 0);
    bf = '1;
    for (int k = 0; k < 4000; k++) begin
      st = 8'($urandom);
      bf = 4'($urandom) | 4'($urandom);
      sf = 4'($urandom) & 4'($urandom) & 4'($urandom);
      dr = 4'($urandom) & 4'($urandom);
      rv = 1'($urandom);
      rt = 2'($urandom);
      if (k % 997 == 500) begin
        do_reset();
        step(); chk(ob_gv == 0, "R1 no grant after reset", ob_gv, 0);
      end else begin
        step();
      end
    end
    done = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    #(8 * 200000);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end
endmodule